// File: doc/BRIEF.md
# Break- and Idle-Sequencing Serial Transmitter

This block serialises 8-bit or 9-bit characters onto a single transmit line. It also produces two kinds of special character in hardware: a break, which holds the line low for a whole character, and an idle character, which holds it high for a whole character. Every bit lasts one pulse of an external baud tick. The block does not divide the clock and does not generate parity.

Data enters through a valid/ready stream into a one-word holding register. `s_ready` is high exactly while that register is empty. A word is taken on a clock edge where both `s_valid` and `s_ready` are high. While `s_ready` is low, the source must hold `s_valid` and `s_data` steady. The holding register passes its word to the shift register at a character boundary.

Control is through three plain inputs:
- `tx_en` enables sending. Each rising edge of `tx_en` queues one idle character.
- `send_brk` requests break characters for as long as it is high.
- `char9` selects the character length.

The sequencer picks the next character in this order: queued idle, then break, then the trailing mark after a break, then data.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset `txd` is 1, and `tx_empty`, `tx_done` and `s_ready` are all 1.
- R2: `s_ready` and `tx_empty` are high only while the holding register is empty. While it is full, a word offered on `s_valid` is not accepted. The held word is the next data character sent.
- R3: A data character is sent as follows. First a start bit of 0. Then data bits 0..7, least significant first. Then, when `char9`=1, bit 8 of `s_data`. Finally a stop bit of 1. The character is 10 bit times long with `char9`=0 and 11 with `char9`=1.
- R4: A rising edge of `tx_en` queues one idle character: 10 or 11 bit times of 1, with the length set by `char9`. This idle character is sent before any break or data.
- R5: While `send_brk` is 1, the block sends break characters back to back. Each break is 10 or 11 bit times of 0, with no start bit and no stop bit.
- R6: When the last break ends and no idle character is queued, one extra bit time of 1 is sent before any following start bit.
- R7: A break followed directly by a queued idle character keeps the line low for the whole break length.
- R8: If `tx_en` goes low while a character is being sent, that character completes. The line then stays at 1 and nothing new starts until `tx_en` rises again.
- R9: Suppose `tx_en` falls and rises again during a character, before its stop bit starts. Then one idle character is sent after that character, and the held data follows the idle character.
- R10: If `tx_en` is 0 when the stop bit of a data character starts, the word in the holding register is discarded.
- R11: `tx_done` is 1 only when all of the following hold: the shift register is idle, the holding register is empty, no idle character is queued, and no trailing mark is owed.
- R12: `txd` changes only on a clock edge where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, once per bit time |
| tx_en | input | 1 | Transmit enable; a rising edge queues an idle character |
| send_brk | input | 1 | Request break characters while high |
| char9 | input | 1 | 0: 8 data bits; 1: 9 data bits |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Holding register empty, so a word can be accepted |
| s_data | input | 9 | Stream word; bit 8 is the ninth data bit |
| txd | output | 1 | Serial line, idles at 1 |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Nothing being sent and nothing pending |

## Verification
The hardest situations to reach are those where enable or break changes at a particular bit inside a character. Two examples are an enable pulse that arrives in the middle of a break, and enable that is still low when a stop bit begins with a word waiting. The bench reaches these by counting baud ticks from the start of a character and changing `tx_en` or `send_brk` between two chosen ticks. It then compares every following bit with a pattern built from the requirements. Random batches of back-to-back words in both lengths cover the normal data path.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_BREAK = 2'd1,
    FK_IDLE  = 2'd2,
    FK_MARK  = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  input  logic              take,
  input  logic              flush,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (full && (take || flush)) begin
      full <= 1'b0;
    end else if (s_valid && !full) begin
      full <= 1'b1;
      word <= s_data;
    end
  end
endmodule

// File: rtl/uart_tx_sel.sv
module uart_tx_sel
  import uart_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        send_brk,
  input  logic        hold_full,
  input  logic        frame_end,
  input  logic        stop_start,
  output logic        load,
  output frame_kind_e kind,
  output logic        take,
  output logic        flush,
  output logic        idle_pend,
  output logic        mark_pend
);
  logic en_q;
  logic en_rise;

  assign en_rise = tx_en && !en_q;

  always_comb begin
    if (idle_pend)      kind = FK_IDLE;
    else if (send_brk)  kind = FK_BREAK;
    else if (mark_pend) kind = FK_MARK;
    else                kind = FK_DATA;
  end

  assign load  = frame_end && tx_en && (idle_pend || send_brk || mark_pend || hold_full);
  assign take  = load && (kind == FK_DATA);
  assign flush = stop_start && !tx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      idle_pend <= 1'b0;
      mark_pend <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (load && kind == FK_IDLE) idle_pend <= 1'b0;
      else if (en_rise)            idle_pend <= 1'b1;
      if (load) mark_pend <= (kind == FK_BREAK);
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  frame_kind_e          kind,
  input  logic [DATA_BITS:0]   word,
  input  logic                 char9,
  output logic                 txd,
  output logic                 busy,
  output logic                 frame_end,
  output logic                 stop_start,
  output frame_kind_e          cur_kind
);
  localparam int FRAME_W = DATA_BITS + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] data_pat;
  logic [FRAME_W-1:0] next_pat;
  logic [CNT_W-1:0]   char_len;
  logic [CNT_W-1:0]   next_len;

  always_comb begin
    data_pat    = '1;
    data_pat[0] = 1'b0;
    for (int i = 0; i < DATA_BITS; i++) data_pat[i+1] = word[i];
    if (char9) data_pat[DATA_BITS+1] = word[DATA_BITS];
  end

  assign char_len = char9 ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);

  always_comb begin
    unique case (kind)
      FK_DATA:  begin next_pat = data_pat; next_len = char_len;   end
      FK_BREAK: begin next_pat = '0;       next_len = char_len;   end
      FK_IDLE:  begin next_pat = '1;       next_len = char_len;   end
      default:  begin next_pat = '1;       next_len = CNT_W'(1);  end
    endcase
  end

  assign frame_end  = tick && (!busy || cnt == CNT_W'(1));
  assign stop_start = tick && busy && (cur_kind == FK_DATA) && (cnt == CNT_W'(2));
  assign txd        = !busy || shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '1;
      cnt      <= '0;
      cur_kind <= FK_IDLE;
    end else if (frame_end) begin
      if (load) begin
        busy     <= 1'b1;
        shreg    <= next_pat;
        cnt      <= next_len;
        cur_kind <= kind;
      end else begin
        busy <= 1'b0;
      end
    end else if (tick && busy) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      cnt   <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 tx_en,
  input  logic                 send_brk,
  input  logic                 char9,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DATA_BITS:0]   s_data,
  output logic                 txd,
  output logic                 tx_empty,
  output logic                 tx_done
);
  localparam int WORD_W = DATA_BITS + 1;

  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic              take;
  logic              flush;
  logic              load;
  frame_kind_e       kind;
  logic              idle_pend;
  logic              mark_pend;
  logic              sh_busy;
  logic              frame_end;
  logic              stop_start;
  frame_kind_e       sh_kind;

  uart_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .take(take), .flush(flush), .full(hold_full), .word(hold_word)
  );

  uart_tx_sel u_sel (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .send_brk(send_brk),
    .hold_full(hold_full), .frame_end(frame_end), .stop_start(stop_start),
    .load(load), .kind(kind), .take(take), .flush(flush),
    .idle_pend(idle_pend), .mark_pend(mark_pend)
  );

  uart_tx_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load), .kind(kind),
    .word(hold_word), .char9(char9), .txd(txd), .busy(sh_busy),
    .frame_end(frame_end), .stop_start(stop_start), .cur_kind(sh_kind)
  );

  assign s_ready  = !hold_full;
  assign tx_empty = !hold_full;
  assign tx_done  = !sh_busy && !hold_full && !idle_pend && !mark_pend;
endmodule

// File: rtl/uart_tx_seq_chk.sv
module uart_tx_seq_chk
  import uart_tx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        baud_tick,
  input logic        tx_en,
  input logic        s_valid,
  input logic        s_ready,
  input logic        tx_empty,
  input logic        tx_done,
  input logic        txd,
  input logic        sh_busy,
  input frame_kind_e sh_kind
);
  p_line_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !tx_empty);

  p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !sh_busy) |=> !sh_busy);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (txd && tx_empty));

  p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && sh_kind == FK_BREAK) |-> !txd);

  p_fill_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && (sh_kind == FK_IDLE || sh_kind == FK_MARK)) |-> txd);
endmodule

bind uart_tx_seq uart_tx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
  .s_valid(s_valid), .s_ready(s_ready), .tx_empty(tx_empty),
  .tx_done(tx_done), .txd(txd), .sh_busy(sh_busy), .sh_kind(sh_kind)
);

// File: tb/uart_tx_seq_test.sv
module uart_tx_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       send_brk = 1'b0;
  logic       char9 = 1'b0;
  logic       s_valid = 1'b0;
  logic [8:0] s_data = '0;
  logic       s_ready;
  logic       txd;
  logic       tx_empty;
  logic       tx_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_tx_seq uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .send_brk(send_brk), .char9(char9), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] frame_of(input logic [8:0] d, input bit m);
    logic [11:0] p;
    p = 12'hFFF;
    p[0] = 1'b0;
    p[8:1] = d[7:0];
    if (m) p[9] = d[8];
    return p;
  endfunction

  function automatic int len_of(input bit m);
    return m ? 11 : 10;
  endfunction

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic expect_range(input logic [11:0] pat, input int from, input int upto, input string tag);
    for (int i = from; i < upto; i++) begin
      logic held;
      tick();
      check($sformatf("%s bit %0d", tag, i), txd, pat[i]);
      held = txd;
      @(negedge clk);
      check($sformatf("R12 steady bit %0d", i), txd, held);
    end
  endtask

  task automatic expect_rest();
    tick();
    check("R11 line high after sequence", txd, 1'b1);
    check("R11 done after sequence", tx_done, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", txd, 1'b1);
    check("R1 tx_empty", tx_empty, 1'b1);
    check("R1 tx_done", tx_done, 1'b1);
    check("R1 s_ready", s_ready, 1'b1);

    // R2 / R8: a word written while disabled waits, and back-pressure holds a second offer off
    write_word(9'h0A5);
    check("R2 ready low when full", s_ready, 1'b0);
    check("R2 empty low when full", tx_empty, 1'b0);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = 9'h03C;
    repeat (2) @(negedge clk);
    s_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 no start while disabled", txd, 1'b1);
    end

    // R4 preamble on enable, then the held word (R2, R3)
    @(negedge clk) tx_en = 1'b1;
    @(negedge clk);
    check("R11 done low with idle queued", tx_done, 1'b0);
    expect_range(12'hFFF, 0, 10, "R4 preamble");
    expect_range(frame_of(9'h0A5, 1'b0), 0, 10, "R2 held word");
    check("R2 empty after load", tx_empty, 1'b1);
    expect_rest();

    // R3: nine-bit character
    char9 = 1'b1;
    write_word(9'h13C);
    expect_range(frame_of(9'h13C, 1'b1), 0, 11, "R3 nine-bit");
    expect_rest();

    // R5 / R6: repeated break, trailing mark, then data
    send_brk = 1'b1;
    expect_range(12'h000, 0, 11, "R5 break first");
    expect_range(12'h000, 0, 2, "R5 break second");
    @(negedge clk) send_brk = 1'b0;
    write_word(9'h0AA);
    expect_range(12'h000, 2, 11, "R5 break second");
    expect_range(12'hFFF, 0, 1, "R6 trailing mark");
    expect_range(frame_of(9'h0AA, 1'b1), 0, 11, "R6 data after mark");
    expect_rest();

    // R7: break followed by a queued idle character
    char9 = 1'b0;
    send_brk = 1'b1;
    expect_range(12'h000, 0, 4, "R7 break");
    @(negedge clk);
    send_brk = 1'b0;
    tx_en = 1'b0;
    @(negedge clk) tx_en = 1'b1;
    expect_range(12'h000, 4, 10, "R7 break full length");
    expect_range(12'hFFF, 0, 10, "R7 idle after break");
    expect_rest();

    // R8 / R10: disable mid-character, held word discarded
    write_word(9'h05A);
    expect_range(frame_of(9'h05A, 1'b0), 0, 1, "R8 frame");
    write_word(9'h0C3);
    expect_range(frame_of(9'h05A, 1'b0), 1, 4, "R8 frame");
    @(negedge clk) tx_en = 1'b0;
    expect_range(frame_of(9'h05A, 1'b0), 4, 10, "R8 frame completes");
    check("R10 held word discarded", tx_empty, 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R8 line idle after disable", txd, 1'b1);
    end
    check("R11 done while disabled", tx_done, 1'b1);
    @(negedge clk) tx_en = 1'b1;
    @(negedge clk);
    check("R11 done low after enable", tx_done, 1'b0);
    expect_range(12'hFFF, 0, 10, "R4 preamble after re-enable");
    tick();
    check("R10 nothing follows preamble", txd, 1'b1);
    check("R10 done", tx_done, 1'b1);

    // R9: enable toggled before stop bit queues idle between characters
    write_word(9'h011);
    expect_range(frame_of(9'h011, 1'b0), 0, 1, "R9 first");
    write_word(9'h0EE);
    expect_range(frame_of(9'h011, 1'b0), 1, 3, "R9 first");
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk) tx_en = 1'b1;
    expect_range(frame_of(9'h011, 1'b0), 3, 10, "R9 first");
    expect_range(12'hFFF, 0, 10, "R9 queued idle");
    expect_range(frame_of(9'h0EE, 1'b0), 0, 10, "R9 held word");
    expect_rest();

    // R3: random back-to-back batches in both lengths
    for (int b = 0; b < 8; b++) begin
      bit m;
      int n;
      logic [8:0] w [4];
      m = bit'($urandom % 2);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) w[k] = 9'($urandom);
      char9 = m;
      write_word(w[0]);
      for (int k = 0; k < n; k++) begin
        expect_range(frame_of(w[k], m), 0, 1, "R3 random");
        if (k < n - 1) write_word(w[k+1]);
        expect_range(frame_of(w[k], m), 1, len_of(m), "R3 random");
      end
      expect_rest();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule